// File: doc/BRIEF.md
# Path Status Byte Transmit Generator

This block assembles the outgoing path status byte once per frame. At every frame strobe it registers a new byte whose upper four bits report the far-end error count (taken from the local parity error count of the incoming path) and whose next three bits report the remote defect state (derived from local path alarms or set by hand). The byte is held steady between strobes, so downstream overhead insertion can read it at any point in the frame.

Several controls reshape the byte. The error field can be forced to zero. A one-shot request sends a 4-bit error pattern in the error field for exactly one frame. The defect field can take its code from a manual input instead of the alarm encoder. An override hands the whole byte to an external overhead bus, above every other control. The block uses SONET bit numbering: byte bit 1 is the MSB, so bits 1-4 are `status_byte[7:4]`, bits 5-7 are `status_byte[3:1]` and bit 8 is `status_byte[0]`.

Top module: `psg_path_status_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first frame strobe, `status_byte` is 8'h00 and no inject request is pending.
- R2: `status_byte` changes only on the clock edge where `frame_stb` is high; it holds its value on every other edge.
- R3: With override, inject and error-field enable considered as below, `status_byte[7:4]` takes the value of `perr_cnt` sampled at the strobe, clamped to at most 8 (counts 9 and above are sent as 4'b1000).
- R4: When `rei_enable` is low and no inject applies, `status_byte[7:4]` is 4'b0000.
- R5: A pulse on `inj_req` in a cycle without a strobe is held pending; at the next strobe `status_byte[7:4]` becomes `inj_pattern` (sampled at that strobe), even if `rei_enable` is low, and the pending request is cleared, so the strobe after that returns to the count of R3/R4.
- R6: An `inj_req` pulse in the same cycle as the strobe applies to that strobe.
- R7: With `rdi_manual` low, `status_byte[3:1]` is 3'b101 when `alm_server` is high; else 3'b110 when `alm_connect` is high; else 3'b010 when `alm_payload` is high; else 3'b000.
- R8: With `rdi_manual` high, `status_byte[3:1]` equals `rdi_man_code` regardless of the alarm inputs.
- R9: Without override, `status_byte[0]` is always 0.
- R10: With `bus_override` high at a strobe, `status_byte` equals `bus_byte` whatever the other controls are; a pending inject is still consumed by that strobe and does not appear in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking the frame boundary |
| perr_cnt | input | CNT_W (4) | Parity errors detected on the incoming path in the last frame |
| alm_server | input | 1 | Server-class path alarm active |
| alm_connect | input | 1 | Connectivity-class path alarm active |
| alm_payload | input | 1 | Payload-class path alarm active |
| rei_enable | input | 1 | Enables the error-count field |
| rdi_manual | input | 1 | Selects the manual defect code |
| rdi_man_code | input | 3 | Manual defect code for bits 5-7 |
| inj_pattern | input | 4 | Error pattern for one-shot injection |
| inj_req | input | 1 | One-shot inject request pulse |
| bus_override | input | 1 | Takes the whole byte from `bus_byte` |
| bus_byte | input | 8 | External overhead bus byte |
| status_byte | output | 8 | Registered path status byte to transmit |

## Verification
The bench builds the block with its default parameters: a 4-bit count input, a clamp limit of 8 and the enhanced defect encoder. A 4-bit count lets the sweep walk every count value from 0 to 15, so both sides of the clamp are covered, crossed with every alarm combination and both states of the error-field enable. The small field widths also make it cheap to sweep all eight manual codes and to place inject requests before, on and across override strobes.

// File: rtl/psg_pkg.sv
package psg_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned FLD_W  = 4;
   localparam int unsigned CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      DEF_NONE    = 3'b000,
      DEF_PAYLOAD = 3'b010,
      DEF_ONEBIT  = 3'b100,
      DEF_SERVER  = 3'b101,
      DEF_CONNECT = 3'b110
   } defect_code_e;

   typedef struct packed {
      logic [FLD_W-1:0]  err_fld;
      logic [CODE_W-1:0] def_fld;
      logic              spare;
   } status_t;

endpackage

// File: rtl/psg_err_field.sv
module psg_err_field #(
   parameter int unsigned CNT_W   = 4,
   parameter int unsigned FLD_W   = 4,
   parameter int unsigned CLAMP_V = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] perr_cnt,
   input  logic             rei_enable,
   input  logic             inj_hit,
   input  logic [FLD_W-1:0] inj_pattern,
   output logic [FLD_W-1:0] err_fld
);
   localparam logic [CNT_W-1:0] CLAMP_CNT = CNT_W'(CLAMP_V);
   localparam logic [FLD_W-1:0] CLAMP_FLD = FLD_W'(CLAMP_V);

   if (CLAMP_V >= (1 << FLD_W)) begin : g_bad_clamp
      $error("CLAMP_V does not fit in the error field");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [FLD_W-1:0] cnt_clamped;

   if (CLAMP_V >= (1 << CNT_W) - 1) begin : g_no_clamp
      always_comb cnt_clamped = FLD_W'(perr_cnt);
   end else begin : g_clamp
      always_comb begin
         if (perr_cnt > CLAMP_CNT) cnt_clamped = CLAMP_FLD;
         else                      cnt_clamped = FLD_W'(perr_cnt);
      end
   end

   always_comb begin
      if (inj_hit)          err_fld = inj_pattern;
      else if (rei_enable)  err_fld = cnt_clamped;
      else                  err_fld = '0;
   end

   // count path never exceeds the clamp limit
   p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_hit && rei_enable) |-> (err_fld <= CLAMP_FLD));
   // disabled field is zero when no inject applies
   p_field_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_hit && !rei_enable) |-> (err_fld == '0));

endmodule

// File: rtl/psg_defect_enc.sv
module psg_defect_enc
   import psg_pkg::*;
#(
   parameter bit ENHANCED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alm_server,
   input  logic              alm_connect,
   input  logic              alm_payload,
   input  logic              rdi_manual,
   input  logic [CODE_W-1:0] rdi_man_code,
   output logic [CODE_W-1:0] def_fld
);
   defect_code_e auto_code;

   if (ENHANCED) begin : g_enhanced
      always_comb begin
         if (alm_server)       auto_code = DEF_SERVER;
         else if (alm_connect) auto_code = DEF_CONNECT;
         else if (alm_payload) auto_code = DEF_PAYLOAD;
         else                  auto_code = DEF_NONE;
      end
      // server class wins over every other alarm
      p_server_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!rdi_manual && alm_server) |-> (def_fld == 3'b101));
      p_connect_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!rdi_manual && !alm_server && alm_connect) |-> (def_fld == 3'b110));
   end else begin : g_onebit
      always_comb begin
         if (alm_server || alm_connect || alm_payload) auto_code = DEF_ONEBIT;
         else                                          auto_code = DEF_NONE;
      end
   end

   always_comb def_fld = rdi_manual ? rdi_man_code : auto_code;

   p_manual_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rdi_manual |-> (def_fld == rdi_man_code));

endmodule

// File: rtl/psg_inject_ctl.sv
module psg_inject_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   input  logic inj_req,
   output logic inj_hit
);
   logic pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pending_q <= 1'b0;
      else if (frame_stb) pending_q <= 1'b0;
      else if (inj_req)   pending_q <= 1'b1;
   end

   always_comb inj_hit = frame_stb && (pending_q || inj_req);

   // a strobe always consumes the request
   p_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> !pending_q);
   // a request between strobes is remembered
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_req && !frame_stb) |=> pending_q);
   // a request on the strobe takes effect at once
   p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_req && frame_stb) |-> inj_hit);

endmodule

// File: rtl/psg_path_status_gen.sv
module psg_path_status_gen
   import psg_pkg::*;
#(
   parameter int unsigned CNT_W        = 4,
   parameter int unsigned CLAMP_V      = 8,
   parameter bit          ENHANCED_DEF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic [CNT_W-1:0]  perr_cnt,
   input  logic              alm_server,
   input  logic              alm_connect,
   input  logic              alm_payload,
   input  logic              rei_enable,
   input  logic              rdi_manual,
   input  logic [CODE_W-1:0] rdi_man_code,
   input  logic [FLD_W-1:0]  inj_pattern,
   input  logic              inj_req,
   input  logic              bus_override,
   input  logic [BYTE_W-1:0] bus_byte,
   output logic [BYTE_W-1:0] status_byte
);
   if ($bits(status_t) != BYTE_W) begin : g_bad_layout
      $error("status layout must fill one byte");
   end

   logic              inj_hit;
   logic [FLD_W-1:0]  err_fld;
   logic [CODE_W-1:0] def_fld;
   status_t           built;
   logic [BYTE_W-1:0] next_byte;
   logic [BYTE_W-1:0] status_q;

   psg_inject_ctl u_inject (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .inj_req   (inj_req),
      .inj_hit   (inj_hit)
   );

   psg_err_field #(
      .CNT_W   (CNT_W),
      .FLD_W   (FLD_W),
      .CLAMP_V (CLAMP_V)
   ) u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .perr_cnt    (perr_cnt),
      .rei_enable  (rei_enable),
      .inj_hit     (inj_hit),
      .inj_pattern (inj_pattern),
      .err_fld     (err_fld)
   );

   psg_defect_enc #(
      .ENHANCED (ENHANCED_DEF)
   ) u_def (
      .clk          (clk),
      .rst_n        (rst_n),
      .alm_server   (alm_server),
      .alm_connect  (alm_connect),
      .alm_payload  (alm_payload),
      .rdi_manual   (rdi_manual),
      .rdi_man_code (rdi_man_code),
      .def_fld      (def_fld)
   );

   always_comb begin
      built.err_fld = err_fld;
      built.def_fld = def_fld;
      built.spare   = 1'b0;
      next_byte     = bus_override ? bus_byte : BYTE_W'(built);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status_q <= '0;
      else if (frame_stb) status_q <= next_byte;
   end

   assign status_byte = status_q;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(status_byte));
   p_bus_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && bus_override) |=> (status_byte == $past(bus_byte)));
   p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !bus_override) |=> (status_byte[0] == 1'b0));
   p_inject_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && inj_req && !bus_override) |=> (status_byte[7:4] == $past(inj_pattern)));

endmodule

// File: tb/psg_path_status_gen_bench.sv
`timescale 1ns/1ps
module psg_path_status_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_stb = 1'b0;
   logic [3:0] perr_cnt = '0;
   logic       alm_server = 1'b0, alm_connect = 1'b0, alm_payload = 1'b0;
   logic       rei_enable = 1'b1, rdi_manual = 1'b0;
   logic [2:0] rdi_man_code = '0;
   logic [3:0] inj_pattern = '0;
   logic       inj_req = 1'b0, bus_override = 1'b0;
   logic [7:0] bus_byte = '0;
   logic [7:0] status_byte;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   psg_path_status_gen u_psg_path_status_gen (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .perr_cnt(perr_cnt),
      .alm_server(alm_server), .alm_connect(alm_connect), .alm_payload(alm_payload),
      .rei_enable(rei_enable), .rdi_manual(rdi_manual), .rdi_man_code(rdi_man_code),
      .inj_pattern(inj_pattern), .inj_req(inj_req), .bus_override(bus_override),
      .bus_byte(bus_byte), .status_byte(status_byte));

   task automatic check(input logic [7:0] exp, input string req);
      n_cmp++;
      if (status_byte !== exp) begin
         n_bad++;
         $display("FAIL %s: status_byte=%h expected=%h", req, status_byte, exp);
      end
   endtask

   // expected byte from the requirements, inject given explicitly
   function automatic logic [7:0] expect_byte(input bit inj);
      int          cnt;
      logic [3:0]  ef;
      logic [2:0]  df;
      if (bus_override) return bus_byte;
      cnt = (int'(perr_cnt) > 8) ? 8 : int'(perr_cnt);
      if (inj)             ef = inj_pattern;
      else if (rei_enable) ef = 4'(cnt);
      else                 ef = 4'd0;
      if (rdi_manual)       df = rdi_man_code;
      else if (alm_server)  df = 3'b101;
      else if (alm_connect) df = 3'b110;
      else if (alm_payload) df = 3'b010;
      else                  df = 3'b000;
      return {ef, df, 1'b0};
   endfunction

   // one strobe; inputs already set; sample after the registering edge
   task automatic strobe(input bit with_req);
      @(negedge clk);
      frame_stb = 1'b1;
      inj_req   = with_req;
      @(negedge clk);
      frame_stb = 1'b0;
      inj_req   = 1'b0;
   endtask

   task automatic request_only();
      @(negedge clk);
      inj_req = 1'b1;
      @(negedge clk);
      inj_req = 1'b0;
   endtask

   initial begin
      logic [7:0] exp;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      check(8'h00, "R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(8'h00, "R1 after reset");

      // R2: inputs move, no strobe, output must stay
      perr_cnt = 4'd5; alm_server = 1'b1; bus_override = 1'b1; bus_byte = 8'hA5;
      repeat (4) @(negedge clk);
      check(8'h00, "R2 hold without strobe");
      bus_override = 1'b0; alm_server = 1'b0;

      // R3 R4 R7 R9: sweep counts, enable and alarm combinations
      for (int en = 0; en < 2; en++) begin
         for (int al = 0; al < 8; al++) begin
            for (int c = 0; c < 16; c++) begin
               rei_enable  = en[0];
               alm_server  = al[2];
               alm_connect = al[1];
               alm_payload = al[0];
               perr_cnt    = 4'(c);
               exp = expect_byte(1'b0);
               strobe(1'b0);
               check(exp, en ? "R3 R7 R9 count and auto code" : "R4 R7 field disabled");
            end
         end
      end

      // R2 again: hold a nonzero value across idle cycles
      held = status_byte;
      perr_cnt = 4'd1; alm_server = 1'b0;
      repeat (5) @(negedge clk);
      check(held, "R2 nonzero hold");

      // R8: manual codes override alarms
      rdi_manual = 1'b1; alm_server = 1'b1; alm_connect = 1'b1; rei_enable = 1'b1;
      for (int m = 0; m < 8; m++) begin
         rdi_man_code = 3'(m);
         perr_cnt = 4'(m + 3);
         exp = expect_byte(1'b0);
         strobe(1'b0);
         check(exp, "R8 manual code");
      end
      rdi_manual = 1'b0; alm_server = 1'b0; alm_connect = 1'b0; alm_payload = 1'b0;

      // R5: pending request, pattern once, then count again; enable low
      rei_enable = 1'b0; perr_cnt = 4'd6;
      for (int p = 0; p < 16; p++) begin
         request_only();
         inj_pattern = 4'(p);
         repeat (2) @(negedge clk);
         exp = expect_byte(1'b1);
         strobe(1'b0);
         check(exp, "R5 pattern sent");
         exp = expect_byte(1'b0);
         strobe(1'b0);
         check(exp, "R5 one frame only");
      end
      rei_enable = 1'b1;

      // R6: request on the strobe cycle
      inj_pattern = 4'hC; perr_cnt = 4'd2;
      exp = expect_byte(1'b1);
      strobe(1'b1);
      check(exp, "R6 same-cycle inject");
      exp = expect_byte(1'b0);
      strobe(1'b0);
      check(exp, "R6 no repeat");

      // R10: override wins and consumes a pending request
      request_only();
      inj_pattern = 4'h9;
      for (int b = 0; b < 8; b++) begin
         bus_override = 1'b1;
         bus_byte = 8'(8'h3C ^ (b * 37));
         rdi_manual = b[0]; rei_enable = b[1]; alm_server = b[2];
         exp = expect_byte(1'b0);
         strobe(b == 3);
         check(exp, "R10 bus byte");
      end
      bus_override = 1'b0; rdi_manual = 1'b0; rei_enable = 1'b1; alm_server = 1'b0;
      perr_cnt = 4'd4;
      exp = expect_byte(1'b0);
      strobe(1'b0);
      check(exp, "R10 inject consumed under override");

      // R1: reset mid-run clears output and pending request
      request_only();
      rst_n = 1'b0;
      @(negedge clk);
      check(8'h00, "R1 reset clears");
      rst_n = 1'b1;
      inj_pattern = 4'hF; perr_cnt = 4'd1;
      exp = expect_byte(1'b0);
      strobe(1'b0);
      check(exp, "R1 no pending after reset");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule